// File: doc/BRIEF.md
# Asynchronous Serial Channel

This block is a single asynchronous serial channel with a transmitter and a receiver. Both run from a shared baud tick at sixteen times the bit rate. The tick comes from a 16-bit programmable divisor. An optional divide-by-4 stage can be switched in ahead of the divisor. Configuration inputs set the character length, the parity mode and the number of stop bits. They must not change while a character is in flight.

The host writes a byte through a valid/ready pair. The transmitter serializes it onto `tx`, which idles high. The sender can also hold the line low to signal a break. The receiver synchronizes `rx` and checks the start bit again at its midpoint, so that short glitches are discarded. It samples each following bit at mid-bit. For each character it presents one cycle of `rx_valid` with the data and its error flags.

Top module: `uart_chan`

## Requirements
- R1: After reset `tx` is high, `tx_ready` is high and `rx_valid` stays low.
- R2: A transmitted character starts with one low start bit and then sends `len_sel`+5 data bits, least significant bit first. `len_sel` uses 0→5, 1→6, 2→7, 3→8 bits.
- R3: When `par_en` is 1, one parity bit follows the data. If `par_even` is 1 the bit makes the count of ones in data plus parity even; if `par_even` is 0 it makes that count odd.
- R4: The stop field is high and lasts 1 bit when `two_stop` is 0. When `two_stop` is 1 it lasts 1.5 bits with 5-bit characters and 2 bits otherwise. `tx_ready` returns high at the end of the stop field.
- R5: One bit lasts 16 × D × (`prescale_en` ? 4 : 1) clock cycles, where D is `divisor`. A divisor of 0 acts as 1.
- R6: The receiver presents each character with a single-cycle `rx_valid` pulse. The data is right-aligned in `rx_data` and the unused upper bits are zero.
- R7: `rx_parity_err` is 1 with `rx_valid` when parity is enabled and the received parity bit disagrees with the selected mode.
- R8: `rx_frame_err` is 1 with `rx_valid` when the first stop bit is sampled low and the character is not a break.
- R9: If `rx` stays low through all data, parity and stop bits, exactly one character is reported. It has `rx_data` = 0 and `rx_break` = 1. No further character is reported until `rx` has returned high.
- R10: A low pulse on `rx` that has ended before the middle of the start bit produces no character.
- R11: While `tx_break` is 1, `tx` is low from the next clock on. When it is released, `tx` returns to its normal level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 16 | Baud divisor (0 acts as 1) |
| prescale_en | input | 1 | Adds a divide-by-4 ahead of the divisor |
| len_sel | input | 2 | Data bits: 0→5, 1→6, 2→7, 3→8 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 selects even parity, 0 selects odd |
| two_stop | input | 1 | Long stop field (1.5 or 2 bits) |
| tx_break | input | 1 | Forces the line low |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmitter is idle and takes a byte |
| tx | output | 1 | Serial output |
| rx | input | 1 | Serial input |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | One-cycle character strobe |
| rx_parity_err | output | 1 | Parity mismatch, valid with rx_valid |
| rx_frame_err | output | 1 | Stop bit low, valid with rx_valid |
| rx_break | output | 1 | Break character, valid with rx_valid |

## Verification
A wrong transmitter phase or bit index shows on `tx` within the same character. It appears as a misplaced data or parity bit, or as a `tx_ready` edge that arrives off by a multiple of the tick period. A wrong divisor or prescaler state stretches or shrinks every bit, so the first frame already shows it in the measured duration. A receiver state that is stuck or out of step shows within one character time. It appears as a missing, doubled or mis-flagged `rx_valid` pulse. A break or framing state that does not wait for the line to go high shows as extra characters after the break.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP, PH_HOLD
  } phase_e;

  localparam int OVS = 16;

  function automatic logic [3:0] char_len(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction
endpackage

// File: rtl/uart_chan_baud.sv
module uart_chan_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             prescale_en,
  output logic             tick
);
  logic [1:0]       pre_q, pre_d;
  logic [DIV_W-1:0] cnt_q, cnt_d, lim;
  logic             pre_tick;

  always_comb begin
    lim      = (divisor == '0) ? '0 : divisor - 1'b1;
    pre_tick = !prescale_en || (pre_q == 2'd3);
    pre_d    = prescale_en ? pre_q + 2'd1 : 2'd0;
    cnt_d    = cnt_q;
    tick     = 1'b0;
    if (pre_tick) begin
      if (cnt_q >= lim) begin
        cnt_d = '0;
        tick  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= 2'd0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick && $past(tick) |-> !prescale_en && divisor <= 16'd1);
endmodule

// File: rtl/uart_chan_tx.sv
module uart_chan_tx
  import uart_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] len_sel,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       two_stop,
  input  logic       brk_req,
  input  logic [7:0] din,
  input  logic       din_valid,
  output logic       din_ready,
  output logic       txd
);
  localparam logic [4:0] LAST_ONE = 5'(OVS - 1);
  localparam logic [4:0] LAST_HALF = 5'(OVS + OVS/2 - 1);
  localparam logic [4:0] LAST_TWO = 5'(2*OVS - 1);

  phase_e     ph_q, ph_d;
  logic [4:0] cnt_q, cnt_d, bit_last, stop_last;
  logic [2:0] idx_q, idx_d;
  logic [7:0] sh_q, sh_d, mask, masked;
  logic       par_q, par_d, line;
  logic [3:0] nbits;

  always_comb begin
    nbits     = char_len(len_sel);
    mask      = 8'hFF >> (4'd8 - nbits);
    masked    = din & mask;
    stop_last = !two_stop ? LAST_ONE : (len_sel == 2'd0 ? LAST_HALF : LAST_TWO);
    bit_last  = (ph_q == PH_STOP) ? stop_last : LAST_ONE;
    ph_d  = ph_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    par_d = par_q;
    case (ph_q)
      PH_START: line = 1'b0;
      PH_DATA:  line = sh_q[0];
      PH_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
    if (ph_q == PH_IDLE) begin
      if (din_valid) begin
        ph_d  = PH_START;
        cnt_d = 5'd0;
        sh_d  = masked;
        par_d = par_even ? ^masked : ~^masked;
      end
    end else if (tick) begin
      cnt_d = cnt_q + 5'd1;
      if (cnt_q == bit_last) begin
        cnt_d = 5'd0;
        case (ph_q)
          PH_START: begin
            ph_d  = PH_DATA;
            idx_d = 3'd0;
          end
          PH_DATA: begin
            sh_d = sh_q >> 1;
            if ({1'b0, idx_q} == nbits - 4'd1) ph_d = par_en ? PH_PAR : PH_STOP;
            else idx_d = idx_q + 3'd1;
          end
          PH_PAR:  ph_d = PH_STOP;
          default: ph_d = PH_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= 5'd0;
      idx_q <= 3'd0;
      sh_q  <= 8'd0;
      par_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      par_q <= par_d;
    end
  end

  assign din_ready = (ph_q == PH_IDLE);
  assign txd       = line && !brk_req;

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready && din_valid |=> !txd && !din_ready);
endmodule

// File: rtl/uart_chan_rx.sv
module uart_chan_rx
  import uart_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] len_sel,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       rxd,
  output logic [7:0] dout,
  output logic       dout_valid,
  output logic       perr,
  output logic       ferr,
  output logic       brk
);
  localparam logic [3:0] MID = 4'(OVS/2 - 1);
  localparam logic [3:0] LAST = 4'(OVS - 1);

  phase_e     ph_q, ph_d;
  logic [3:0] cnt_q, cnt_d, nbits;
  logic [2:0] idx_q, idx_d;
  logic [7:0] sh_q, sh_d, got, data_q, data_d;
  logic       s1_q, rx_s, pb_q, pb_d, zero;
  logic       valid_q, valid_d, perr_q, perr_d, ferr_q, ferr_d, brk_q, brk_d;

  always_comb begin
    nbits   = char_len(len_sel);
    got     = sh_q >> (4'd8 - nbits);
    zero    = (got == 8'd0) && !(par_en && pb_q) && !rx_s;
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    pb_d    = pb_q;
    data_d  = data_q;
    valid_d = 1'b0;
    perr_d  = 1'b0;
    ferr_d  = 1'b0;
    brk_d   = 1'b0;
    if (ph_q == PH_IDLE) begin
      if (tick && !rx_s) begin
        ph_d  = PH_START;
        cnt_d = 4'd0;
      end
    end else if (ph_q == PH_HOLD) begin
      if (rx_s) ph_d = PH_IDLE;
    end else if (tick) begin
      cnt_d = cnt_q + 4'd1;
      case (ph_q)
        PH_START: begin
          if (cnt_q == MID && rx_s) ph_d = PH_IDLE;
          else if (cnt_q == LAST) begin
            ph_d  = PH_DATA;
            idx_d = 3'd0;
          end
        end
        PH_DATA: begin
          if (cnt_q == MID) sh_d = {rx_s, sh_q[7:1]};
          if (cnt_q == LAST) begin
            if ({1'b0, idx_q} == nbits - 4'd1) ph_d = par_en ? PH_PAR : PH_STOP;
            else idx_d = idx_q + 3'd1;
          end
        end
        PH_PAR: begin
          if (cnt_q == MID) pb_d = rx_s;
          if (cnt_q == LAST) ph_d = PH_STOP;
        end
        default: begin
          if (cnt_q == MID) begin
            valid_d = 1'b1;
            data_d  = got;
            brk_d   = zero;
            ferr_d  = !rx_s && !zero;
            perr_d  = par_en && !zero && (pb_q != (par_even ? ^got : ~^got));
            ph_d    = rx_s ? PH_IDLE : PH_HOLD;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b1;
      rx_s    <= 1'b1;
      ph_q    <= PH_IDLE;
      cnt_q   <= 4'd0;
      idx_q   <= 3'd0;
      sh_q    <= 8'd0;
      pb_q    <= 1'b0;
      data_q  <= 8'd0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      s1_q    <= rxd;
      rx_s    <= s1_q;
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      pb_q    <= pb_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      brk_q   <= brk_d;
    end
  end

  assign dout       = data_q;
  assign dout_valid = valid_q;
  assign perr       = perr_q;
  assign ferr       = ferr_q;
  assign brk        = brk_q;

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |=> !dout_valid);
  assert_break_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> dout_valid && dout == 8'd0 && !ferr && !perr);
endmodule

// File: rtl/uart_chan.sv
module uart_chan #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             prescale_en,
  input  logic [1:0]       len_sel,
  input  logic             par_en,
  input  logic             par_even,
  input  logic             two_stop,
  input  logic             tx_break,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             tx,
  input  logic             rx,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_parity_err,
  output logic             rx_frame_err,
  output logic             rx_break
);
  logic rst_m_q, rst_s_q, tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  uart_chan_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_s_q), .divisor(divisor),
    .prescale_en(prescale_en), .tick(tick)
  );

  uart_chan_tx u_tx (
    .clk(clk), .rst_n(rst_s_q), .tick(tick), .len_sel(len_sel),
    .par_en(par_en), .par_even(par_even), .two_stop(two_stop),
    .brk_req(tx_break), .din(tx_data), .din_valid(tx_valid),
    .din_ready(tx_ready), .txd(tx)
  );

  uart_chan_rx u_rx (
    .clk(clk), .rst_n(rst_s_q), .tick(tick), .len_sel(len_sel),
    .par_en(par_en), .par_even(par_even), .rxd(rx),
    .dout(rx_data), .dout_valid(rx_valid), .perr(rx_parity_err),
    .ferr(rx_frame_err), .brk(rx_break)
  );

  assert_break_line_R11: assert property (@(posedge clk) disable iff (!rst_s_q)
    $past(tx_break) && tx_break |-> !tx);
endmodule

// File: tb/sim_uart_chan.sv
`timescale 1ns/1ps
module sim_uart_chan;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, prescale_en, par_en, par_even, two_stop, tx_break;
  logic [15:0] divisor;
  logic [1:0] len_sel;
  logic [7:0] tx_data, rx_data;
  logic       tx_valid, tx_ready, tx, rx, rx_valid, rx_parity_err, rx_frame_err, rx_break;
  logic       lb, rx_drv;

  assign rx = lb ? tx : rx_drv;

  uart_chan u0 (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .prescale_en(prescale_en),
    .len_sel(len_sel), .par_en(par_en), .par_even(par_even), .two_stop(two_stop),
    .tx_break(tx_break), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx(tx), .rx(rx), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err), .rx_break(rx_break)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int v_cnt = 0;
  logic [7:0] v_data;
  logic v_perr, v_ferr, v_brk;
  int tickp = 1, P = 16;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rx_valid) begin
      v_cnt  <= v_cnt + 1;
      v_data <= rx_data;
      v_perr <= rx_parity_err;
      v_ferr <= rx_frame_err;
      v_brk  <= rx_break;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setcfg(input int d, input bit pre, input int bits, input bit pe,
                        input bit pev, input bit ts);
    @(negedge clk);
    divisor = 16'(d); prescale_en = pre; len_sel = 2'(bits - 5);
    par_en = pe; par_even = pev; two_stop = ts;
    tickp = (d == 0 ? 1 : d) * (pre ? 4 : 1);
    P = 16 * tickp;
    waitn(2);
  endtask

  function automatic logic par_of(input logic [7:0] v, input bit pev);
    return pev ? ^v : ~^v;
  endfunction

  task automatic tx_frame(input logic [7:0] b, input string req);
    int bits = len_sel + 5;
    logic [7:0] m = 8'hFF >> (8 - bits);
    logic [7:0] got = 8'd0;
    int t0, dur, exp16, expd;
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    t0 = cyc;
    waitn(P / 2);
    chk(tx == 1'b0, {req, " start bit"}, tx, 0);
    for (int k = 0; k < bits; k++) begin
      waitn(P);
      got[k] = tx;
    end
    chk(got == (b & m), {req, " data LSB first"}, got, b & m);
    if (par_en) begin
      waitn(P);
      chk(tx == par_of(b & m, par_even), {req, " parity bit"}, tx, par_of(b & m, par_even));
    end
    waitn(P);
    chk(tx == 1'b1, {req, " stop high"}, tx, 1);
    while (!tx_ready) @(negedge clk);
    dur = cyc - t0;
    exp16 = 16 * (1 + bits + (par_en ? 1 : 0)) + (!two_stop ? 16 : (bits == 5 ? 24 : 32));
    expd = exp16 * tickp;
    chk(dur <= expd && dur > expd - tickp, {req, " frame length"}, dur, expd);
  endtask

  task automatic rx_send(input logic [7:0] b, input bit bad_par, input bit stop_lvl);
    int bits = len_sel + 5;
    logic [7:0] m = 8'hFF >> (8 - bits);
    @(negedge clk);
    rx_drv = 1'b0; waitn(P);
    for (int k = 0; k < bits; k++) begin
      rx_drv = b[k]; waitn(P);
    end
    if (par_en) begin
      rx_drv = par_of(b & m, par_even) ^ bad_par; waitn(P);
    end
    rx_drv = stop_lvl; waitn(P);
    rx_drv = 1'b1; waitn(2 * P);
  endtask

  task automatic rx_expect(input int v0, input logic [7:0] d, input bit pe, input bit fe,
                           input bit bk, input string req);
    chk(v_cnt == v0 + 1, {req, " one character"}, v_cnt - v0, 1);
    chk(v_data == d, {req, " data"}, v_data, d);
    chk({v_perr, v_ferr, v_brk} == {pe, fe, bk}, {req, " flags perr/ferr/brk"},
        {v_perr, v_ferr, v_brk}, {pe, fe, bk});
  endtask

  task automatic t_reset;
    chk(tx == 1'b1, "R1 tx idle", tx, 1);
    chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
    chk(v_cnt == 0, "R1 no rx_valid", v_cnt, 0);
  endtask

  task automatic t_tx_8n1;
    setcfg(0, 0, 8, 0, 0, 0);
    tx_frame(8'hA5, "R2 R5 8N1 div0");
  endtask

  task automatic t_tx_5e_half;
    setcfg(1, 0, 5, 1, 1, 1);
    tx_frame(8'hF3, "R3 R4 5E1.5");
  endtask

  task automatic t_tx_7o2;
    setcfg(2, 0, 7, 1, 0, 1);
    tx_frame(8'h5A, "R3 R4 7O2");
  endtask

  task automatic t_tx_prescale;
    setcfg(2, 1, 6, 0, 0, 0);
    tx_frame(8'h2D, "R5 prescale 6N1");
  endtask

  task automatic t_rx_basic;
    int v0;
    setcfg(1, 0, 8, 0, 0, 0);
    v0 = v_cnt; rx_send(8'h3C, 0, 1);
    rx_expect(v0, 8'h3C, 0, 0, 0, "R6 8N1");
    setcfg(1, 0, 5, 0, 0, 0);
    v0 = v_cnt; rx_send(8'hFB, 0, 1);
    rx_expect(v0, 8'h1B, 0, 0, 0, "R6 5-bit right aligned");
  endtask

  task automatic t_rx_parity;
    int v0;
    setcfg(1, 0, 7, 1, 1, 0);
    v0 = v_cnt; rx_send(8'h41, 1, 1);
    rx_expect(v0, 8'h41, 1, 0, 0, "R7 bad even parity");
    v0 = v_cnt; rx_send(8'h41, 0, 1);
    rx_expect(v0, 8'h41, 0, 0, 0, "R7 good even parity");
  endtask

  task automatic t_rx_frame;
    int v0;
    setcfg(1, 0, 8, 0, 0, 0);
    v0 = v_cnt; rx_send(8'h55, 0, 0);
    rx_expect(v0, 8'h55, 0, 1, 0, "R8 stop low");
  endtask

  task automatic t_rx_break;
    int v0;
    setcfg(1, 0, 8, 1, 0, 0);
    v0 = v_cnt;
    @(negedge clk);
    rx_drv = 1'b0; waitn(14 * P);
    rx_drv = 1'b1; waitn(3 * P);
    rx_expect(v0, 8'h00, 0, 0, 1, "R9 break");
  endtask

  task automatic t_false_start;
    int v0;
    setcfg(1, 0, 8, 0, 0, 0);
    v0 = v_cnt;
    @(negedge clk);
    rx_drv = 1'b0; waitn(P / 4);
    rx_drv = 1'b1; waitn(14 * P);
    chk(v_cnt == v0, "R10 glitch ignored", v_cnt - v0, 0);
    v0 = v_cnt; rx_send(8'h81, 0, 1);
    rx_expect(v0, 8'h81, 0, 0, 0, "R10 receiver still usable");
  endtask

  task automatic t_tx_break;
    setcfg(1, 0, 8, 0, 0, 0);
    @(negedge clk); tx_break = 1'b1;
    @(negedge clk);
    chk(tx == 1'b0, "R11 break low", tx, 0);
    waitn(3 * P);
    chk(tx == 1'b0, "R11 break held", tx, 0);
    tx_break = 1'b0;
    @(negedge clk);
    chk(tx == 1'b1, "R11 break released", tx, 1);
  endtask

  task automatic t_loopback;
    int v0;
    setcfg(1, 0, 8, 1, 0, 0);
    lb = 1'b1;
    v0 = v_cnt;
    tx_frame(8'hC3, "R2 R3 loopback 8O1");
    waitn(4);
    rx_expect(v0, 8'hC3, 0, 0, 0, "R6 loopback");
    lb = 1'b0;
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; divisor = 16'd1; prescale_en = 1'b0; len_sel = 2'd3;
    par_en = 1'b0; par_even = 1'b0; two_stop = 1'b0; tx_break = 1'b0;
    tx_data = 8'd0; tx_valid = 1'b0; lb = 1'b0; rx_drv = 1'b1;
    waitn(4);
    rst_n = 1'b1;
    waitn(4);
    t_reset();
    t_tx_8n1();
    t_tx_5e_half();
    t_tx_7o2();
    t_tx_prescale();
    t_rx_basic();
    t_rx_parity();
    t_rx_frame();
    t_rx_break();
    t_false_start();
    t_tx_break();
    t_loopback();
    finish_run();
  end
endmodule